// File: doc/BRIEF.md
# Line Feed Supervisory State Machine

This block supervises one power-feed line driver. It holds the driver in one of four states: off, feeding, a tolerated-overload state and a stopped state. Its inputs are two control bits (feed request and automatic restart), comparator flags from the analog side (current at the limit, current at one and a half times the limit, temperature over the nominal threshold, temperature over the raised threshold), a strap that enables overload timing, and a flag that reports over-temperature on a neighbouring line. From these it drives the switch enable, requests current limiting, and raises the overload and interrupt flags.

Overload timing uses a digital timer that counts ticks from an internal prescaler. A fault opens a first window of `T1_TICKS` ticks, in which the current is only limited. A second window runs up to 15 times that length, and a third runs up to 50 times that length. Once started, the timer runs to its end even if the current falls back. After a trip the line restarts by itself when the timer ends, or, with restart disabled, it falls back to off. In that case it asks for the feed request bit to be cleared and ignores feed requests for `LOCK_TICKS` ticks. Software acknowledges a fault with a one-cycle `ack`. The analog switch and the sensing are outside the block.

Top module: `lfeed_supervisor`

## Requirements
- R1: Reset, asserted low on `rst_n`, drives `drv_en`, `drv_on`, `ilimit_req`, `ovl_flag`, `irq` and `on_clear_req` low and places the line in the off state.
- R2: With `on_bit`=1 and no lockout, the off state moves to feeding and raises `drv_en`. Dropping `on_bit` returns the line to off and lowers `drv_en` on the next clock.
- R3: In feeding with `timing_en`=1, `oc_imax`=1 enters the overload state and starts the fault timer. During the first `T1_TICKS` ticks there is no trip, even with `oc_high`=1, and `ilimit_req` follows `oc_imax`.
- R4: From `T1_TICKS` up to 15·`T1_TICKS` ticks, the line trips when `oc_high`=1. In that window, `oc_imax` alone does not trip it.
- R5: From 15·`T1_TICKS` up to 50·`T1_TICKS` ticks, `oc_imax`=1 trips the line.
- R6: Once started, the fault timer keeps running after the current drops, so a later `oc_imax` in the third window still trips. When 50·`T1_TICKS` ticks pass with no trip, the line returns to feeding, and a new overload opens a fresh first window.
- R7: With `timing_en`=0, an overcurrent only raises `ilimit_req` while the driver is on. The line never trips on current and `ovl_flag` stays low.
- R8: A current trip lowers `drv_en` and sets both `ovl_flag` and `irq`.
- R9: Stopped with `ar_bit`=1, the line returns to feeding when the fault timer reaches 50·`T1_TICKS` ticks, and `on_clear_req` is not asserted.
- R10: Stopped with `ar_bit`=0, the line goes to off and raises `on_clear_req` for exactly one cycle. For `LOCK_TICKS` ticks after that, `on_bit`=1 is ignored. Once the lockout ends, a held `on_bit` turns the line on again.
- R11: The over-temperature condition is `temp_nom` when `other_hot`=0 and `temp_raised` when `other_hot`=1. It stops a feeding line and sets `irq`, but not `ovl_flag`.
- R12: A one-cycle `ack` clears `irq` and `ovl_flag` when the line is not stopped. While the line is stopped, `ack` has no effect.
- R13: Dropping `on_bit` clears the fault timer, so an overload after the next turn-on starts again in the first window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_bit | input | 1 | Feed request control bit |
| ar_bit | input | 1 | Automatic restart enable |
| timing_en | input | 1 | Strap that enables overload timing |
| oc_imax | input | 1 | Line current at or above the limit |
| oc_high | input | 1 | Line current at or above 1.5 times the limit |
| temp_nom | input | 1 | Driver temperature above the nominal threshold |
| temp_raised | input | 1 | Driver temperature above the raised threshold |
| other_hot | input | 1 | Another line is over temperature |
| ack | input | 1 | One-cycle fault acknowledge |
| drv_en | output | 1 | Line switch enable |
| drv_on | output | 1 | Registered on/off status of the driver |
| ilimit_req | output | 1 | Current limiting request |
| ovl_flag | output | 1 | Current overload trip flag |
| irq | output | 1 | Interrupt request |
| on_clear_req | output | 1 | One-cycle request to clear the feed request bit |

## Verification
The bench builds the block with `PRESCALE`=2, `T1_TICKS`=4 and `LOCK_TICKS`=10. With these values the first window lasts about 8 cycles, the second ends near cycle 120 and the timer ends near cycle 400 after the fault, and the lockout lasts about 20 cycles. Every window edge, the automatic restart and the end of the lockout therefore fall within a few hundred cycles. The bench samples well inside each window, with a margin of a few ticks, so the free-running tick phase cannot change any expected value.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_FEED = 2'd1,
    ST_TPO  = 2'd2,
    ST_STOP = 2'd3
  } feed_state_e;

  typedef enum logic [1:0] {
    PH_LIMIT  = 2'd0,  // first window: limit only
    PH_SURGE  = 2'd1,  // up to 15 x t1: trip at 1.5 x limit
    PH_STRICT = 2'd2,  // up to 50 x t1: trip at limit
    PH_DONE   = 2'd3
  } fault_phase_e;
endpackage

// File: rtl/lfs_tick_gen.sv
module lfs_tick_gen #(
  parameter int unsigned PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/lfs_fault_timer.sv
module lfs_fault_timer
  import lfs_pkg::*;
#(
  parameter int unsigned T1_TICKS = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         clear,
  output fault_phase_e phase,
  output logic         expired
);
  localparam int unsigned T3_TICKS = 15 * T1_TICKS;
  localparam int unsigned T4_TICKS = 50 * T1_TICKS;
  localparam int unsigned W = $clog2(T4_TICKS + 1);
  localparam logic [W-1:0] T1C = W'(T1_TICKS);
  localparam logic [W-1:0] T3C = W'(T3_TICKS);
  localparam logic [W-1:0] T4C = W'(T4_TICKS);

  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run && tick && cnt != T4C) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (cnt < T1C)      phase = PH_LIMIT;
    else if (cnt < T3C) phase = PH_SURGE;
    else if (cnt < T4C) phase = PH_STRICT;
    else                phase = PH_DONE;
  end

  assign expired = run && (cnt == T4C);
endmodule

// File: rtl/lfs_lockout.sv
module lfs_lockout #(
  parameter int unsigned LOCK_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  output logic active
);
  localparam int unsigned W = $clog2(LOCK_TICKS + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= W'(LOCK_TICKS);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/lfeed_supervisor.sv
module lfeed_supervisor
  import lfs_pkg::*;
#(
  parameter int unsigned PRESCALE   = 1000,
  parameter int unsigned T1_TICKS   = 200,
  parameter int unsigned LOCK_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_bit,
  input  logic ar_bit,
  input  logic timing_en,
  input  logic oc_imax,
  input  logic oc_high,
  input  logic temp_nom,
  input  logic temp_raised,
  input  logic other_hot,
  input  logic ack,
  output logic drv_en,
  output logic drv_on,
  output logic ilimit_req,
  output logic ovl_flag,
  output logic irq,
  output logic on_clear_req
);
  feed_state_e  st, nxt;
  fault_phase_e tm_phase;
  logic tick, tm_start, tm_clear, tm_expired;
  logic lock_load, lock_active;
  logic set_ovl, set_irq, over_temp, trip;

  lfs_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lfs_fault_timer #(.T1_TICKS(T1_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tm_start),
    .clear(tm_clear), .phase(tm_phase), .expired(tm_expired)
  );

  lfs_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(lock_load),
    .active(lock_active)
  );

  // A hot neighbour moves this line onto its raised threshold
  assign over_temp = other_hot ? temp_raised : temp_nom;
  assign trip = (tm_phase == PH_SURGE  && oc_high) ||
                (tm_phase == PH_STRICT && oc_imax);

  always_comb begin
    nxt       = st;
    tm_start  = 1'b0;
    tm_clear  = 1'b0;
    lock_load = 1'b0;
    set_ovl   = 1'b0;
    set_irq   = 1'b0;
    case (st)
      ST_OFF: begin
        tm_clear = 1'b1;
        if (on_bit && !lock_active) nxt = ST_FEED;
      end
      ST_FEED: begin
        if (!on_bit) begin
          nxt = ST_OFF; tm_clear = 1'b1;
        end else if (over_temp) begin
          nxt = ST_STOP; tm_start = 1'b1; set_irq = 1'b1;
        end else if (oc_imax && timing_en) begin
          nxt = ST_TPO; tm_start = 1'b1;
        end
      end
      ST_TPO: begin
        if (!on_bit) begin
          nxt = ST_OFF; tm_clear = 1'b1;
        end else if (!timing_en) begin
          nxt = ST_FEED; tm_clear = 1'b1;
        end else if (over_temp) begin
          nxt = ST_STOP; set_irq = 1'b1;
        end else if (trip) begin
          nxt = ST_STOP; set_irq = 1'b1; set_ovl = 1'b1;
        end else if (tm_expired) begin
          nxt = ST_FEED; tm_clear = 1'b1;
        end
      end
      default: begin  // ST_STOP
        if (!on_bit) begin
          nxt = ST_OFF; tm_clear = 1'b1;
        end else if (!ar_bit) begin
          nxt = ST_OFF; tm_clear = 1'b1; lock_load = 1'b1;
        end else if (tm_expired) begin
          if (over_temp) tm_start = 1'b1;
          else begin
            nxt = ST_FEED; tm_clear = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      drv_on       <= 1'b0;
      ovl_flag     <= 1'b0;
      irq          <= 1'b0;
      on_clear_req <= 1'b0;
    end else begin
      st           <= nxt;
      drv_on       <= drv_en;
      on_clear_req <= lock_load;
      if (set_ovl)                    ovl_flag <= 1'b1;
      else if (ack && st != ST_STOP)  ovl_flag <= 1'b0;
      if (set_irq)                    irq <= 1'b1;
      else if (ack && st != ST_STOP)  irq <= 1'b0;
    end
  end

  assign drv_en = (st == ST_FEED) || (st == ST_TPO);
  assign ilimit_req = drv_en && oc_imax &&
                      (!timing_en || st == ST_FEED || tm_phase == PH_LIMIT);
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker (
  input logic clk,
  input logic rst_n,
  input logic on_bit,
  input logic ar_bit,
  input logic timing_en,
  input logic oc_imax,
  input logic oc_high,
  input logic temp_nom,
  input logic temp_raised,
  input logic other_hot,
  input logic ack,
  input logic drv_en,
  input logic drv_on,
  input logic ilimit_req,
  input logic ovl_flag,
  input logic irq,
  input logic on_clear_req
);
  AST_OFF_CMD_DROPS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !on_bit |=> !drv_en); // R2

  AST_TRIP_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag) |-> !drv_en); // R8

  AST_OVL_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_flag |-> irq); // R8

  AST_UNTIMED_NO_OVL: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_en && !ovl_flag) |=> !ovl_flag); // R7

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    on_clear_req |=> !on_clear_req); // R10

  AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    on_clear_req |-> !drv_en); // R10

  AST_AR_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_clear_req) |-> !$past(ar_bit)); // R9

  AST_RAISED_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && on_bit && other_hot && !temp_raised && !oc_imax) |=> drv_en); // R11
endmodule

bind lfeed_supervisor lfs_checker u_lfs_chk (.*);

// File: tb/lfeed_supervisor_tb.sv
module lfeed_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_bit = 1'b0, ar_bit = 1'b0, timing_en = 1'b0;
  logic oc_imax = 1'b0, oc_high = 1'b0;
  logic temp_nom = 1'b0, temp_raised = 1'b0, other_hot = 1'b0, ack = 1'b0;
  logic drv_en, drv_on, ilimit_req, ovl_flag, irq, on_clear_req;

  int checks = 0;
  int failures = 0;
  int clr_cnt = 0;
  int clr_base;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lfeed_supervisor #(.PRESCALE(2), .T1_TICKS(4), .LOCK_TICKS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .on_bit(on_bit), .ar_bit(ar_bit),
    .timing_en(timing_en), .oc_imax(oc_imax), .oc_high(oc_high),
    .temp_nom(temp_nom), .temp_raised(temp_raised), .other_hot(other_hot),
    .ack(ack), .drv_en(drv_en), .drv_on(drv_on), .ilimit_req(ilimit_req),
    .ovl_flag(ovl_flag), .irq(irq), .on_clear_req(on_clear_req)
  );

  always @(negedge clk) if (rst_n && on_clear_req) clr_cnt++;

  typedef struct packed {
    logic       on, ar, ten, oci, och, tn, tr, oth, ak;
    logic       e_drv, e_lim, e_irq, e_ovl;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd2},  // R2 idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd2},  // R2 turn on
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd7},  // R7 limit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd7},  // R7 high
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd7},  // R7 release
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd11}, // R11 raised
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0, 4'd11}, // R11 nominal
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd12}, // R12 ack
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, 4'd11}, // R11 raised hit
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd12}, // R12 ack
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd2}   // R2 on again
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp_v);
    end
  endtask

  task automatic quiet_inputs();
    oc_imax = 1'b0; oc_high = 1'b0; temp_nom = 1'b0;
    temp_raised = 1'b0; other_hot = 1'b0; ack = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0; step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, with a feed request already present
    on_bit = 1'b1;
    step(3);
    chk("R1 drv_en in reset", drv_en, 0);
    chk("R1 flags in reset", {irq, ovl_flag, on_clear_req, ilimit_req, drv_on}, 0);
    on_bit = 1'b0;
    rst_n = 1'b1;
    step(2);
    chk("R1 idle after reset", {drv_en, irq, ovl_flag}, 0);

    // Table walk: basic feed, untimed limiting, thermal thresholds, ack
    for (int i = 0; i < 11; i++) begin
      {on_bit, ar_bit, timing_en, oc_imax, oc_high, temp_nom, temp_raised,
       other_hot, ack} = VECS[i][16:8];
      step(40);
      chk($sformatf("R%0d table[%0d] drv_en", VECS[i].req, i), drv_en, VECS[i].e_drv);
      chk($sformatf("R%0d table[%0d] ilimit_req", VECS[i].req, i), ilimit_req, VECS[i].e_lim);
      chk($sformatf("R%0d table[%0d] irq", VECS[i].req, i), irq, VECS[i].e_irq);
      chk($sformatf("R%0d table[%0d] ovl_flag", VECS[i].req, i), ovl_flag, VECS[i].e_ovl);
    end
    ack = 1'b0;
    chk("R2 drv_on status", drv_on, 1);

    // Test A: high overload, no restart
    timing_en = 1'b1; ar_bit = 1'b0; on_bit = 1'b1;
    step(4);
    chk("R2 feeding before fault", drv_en, 1);
    clr_base = clr_cnt;
    oc_imax = 1'b1; oc_high = 1'b1;
    step(1);
    chk("R3 limit in first window", ilimit_req, 1);
    step(4);
    chk("R3 no trip in first window", {drv_en, irq}, 2'b10);
    step(15);
    chk("R4 trip on high current", drv_en, 0);
    chk("R8 overload flags", {ovl_flag, irq}, 2'b11);
    chk("R10 single clear pulse", clr_cnt - clr_base, 1);
    oc_imax = 1'b0; oc_high = 1'b0;
    step(5);
    chk("R10 feed request ignored in lockout", drv_en, 0);
    step(20);
    chk("R10 feed after lockout", drv_en, 1);
    pulse_ack();
    chk("R12 ack clears flags", {irq, ovl_flag}, 0);

    // Test B: limit-level overload with automatic restart
    ar_bit = 1'b1;
    clr_base = clr_cnt;
    oc_imax = 1'b1;
    step(1);
    step(99);
    chk("R4 limit-level current tolerated in second window", {drv_en, irq}, 2'b10);
    step(51);
    chk("R5 trip in third window", {drv_en, ovl_flag, irq}, 3'b011);
    oc_imax = 1'b0;
    ack = 1'b1; step(1); ack = 1'b0; step(5);
    chk("R12 ack ignored while stopped", {irq, ovl_flag}, 2'b11);
    step(223);
    chk("R9 still stopped before timer end", drv_en, 0);
    step(50);
    chk("R9 automatic restart", drv_en, 1);
    chk("R9 no clear request", clr_cnt - clr_base, 0);
    pulse_ack();

    // Test C: timer keeps running after the current drops
    ar_bit = 1'b0;
    oc_imax = 1'b1; step(1); step(3);
    oc_imax = 1'b0;
    step(126);
    chk("R6 still feeding with low current", drv_en, 1);
    oc_imax = 1'b1;
    step(2);
    chk("R6 late overload trips", {drv_en, ovl_flag}, 2'b01);
    oc_imax = 1'b0; on_bit = 1'b0;
    step(2);
    pulse_ack();
    step(30);
    on_bit = 1'b1;
    step(3);
    chk("R2 feeding again", drv_en, 1);

    // Test D: re-arm after the timer ends
    oc_imax = 1'b1; step(1); step(3);
    oc_imax = 1'b0;
    step(420);
    chk("R6 feeding after timer end", drv_en, 1);
    oc_imax = 1'b1; oc_high = 1'b1;
    step(1); step(4);
    chk("R6 fresh first window", {drv_en, irq}, 2'b10);
    quiet_inputs(); on_bit = 1'b0;
    step(2);

    // Test E: off command resets the timer
    on_bit = 1'b1; step(3);
    oc_imax = 1'b1; step(1); step(3);
    oc_imax = 1'b0;
    step(126);
    on_bit = 1'b0; step(2);
    on_bit = 1'b1; step(3);
    oc_imax = 1'b1; oc_high = 1'b1;
    step(1); step(4);
    chk("R13 timer restarted by off command", {drv_en, irq}, 2'b10);
    quiet_inputs(); on_bit = 1'b0;
    step(2);

    // Test F: long untimed overload
    timing_en = 1'b0; on_bit = 1'b1; step(3);
    oc_imax = 1'b1; oc_high = 1'b1;
    step(500);
    chk("R7 untimed never trips", {drv_en, ovl_flag, irq, ilimit_req}, 4'b1001);
    quiet_inputs(); on_bit = 1'b0;
    step(2);

    // Test G: reset in the middle of a thermal stop
    timing_en = 1'b1; ar_bit = 1'b1; on_bit = 1'b1; temp_nom = 1'b1;
    step(6);
    chk("R11 thermal stop without overload flag", {drv_en, irq, ovl_flag}, 3'b010);
    rst_n = 1'b0;
    step(1);
    chk("R1 reset clears a stop", {drv_en, irq, ovl_flag, on_clear_req}, 0);
    on_bit = 1'b0; temp_nom = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
    chk("R1 off after reset release", {drv_en, drv_on, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule